// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level translation table held in memory. A request carries the virtual address and a flag that says whether the access is a write. The walker latches the table root from its base-register input, fetches one entry from the top-level table, and then fetches one entry from the second-level table that the first entry points to. Each entry is checked for presence and access rights before the walk goes on. The walker then returns either the physical address or a fault code.

The upper ten address bits index the top-level table. The next ten bits index the second-level table. The low twelve bits pass through untranslated. Entries are four bytes wide, so each table fills one 4 KB frame. Memory is reached through a simple read port. The walker holds its read request until the data returns, so the memory may answer with any latency. Handling the fault, caching translations and moving pages to or from storage are left to the surrounding system.

Top module: `page_walker`

## Requirements
- R1: While reset is asserted and right after it is released, the walker is idle: `req_ready` is 1, and `mem_rd_en` and `rsp_valid` are 0.
- R2: The first memory read of a walk goes to `{base[31:12], vaddr[31:22], 2'b00}`, where `base` is the value of `root_base` at the moment the request is accepted. Bits 11:0 of `root_base`, and any later change to it, have no effect on the walk.
- R3: The second read goes to `{e1[31:12], vaddr[21:12], 2'b00}`, where `e1` is the entry returned by the first read.
- R4: An entry is decoded as follows: bit 0 is present, bit 1 is readable, bit 2 is writable, and bits 31:12 are the frame number. The other bits are ignored.
- R5: An entry at either level whose present bit is clear ends the walk at once. The response then has `rsp_fault` = 1 (not present) and `rsp_paddr` = 0, and no further read is issued.
- R6: A present entry at either level gives `rsp_fault` = 2 (protection) if its readable bit is clear, or if the request is a write and its writable bit is clear. The walk ends there with `rsp_paddr` = 0. A read request ignores the writable bit.
- R7: A walk in which both entries pass gives `rsp_fault` = 0 and `rsp_paddr = {e2[31:12], vaddr[11:0]}`, where `e2` is the second-level entry.
- R8: A request is accepted only while `req_ready` is 1, and `req_ready` is 1 only when the walker is idle. A request offered during a walk is ignored: it produces no read and no response.
- R9: `mem_rd_en` stays high with a stable `mem_rd_addr` until a cycle in which `mem_rd_valid` is 1. Any read latency is accepted.
- R10: `rsp_valid` is high for exactly one cycle per accepted request. In the next cycle the walker is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| root_base | input | 32 | Base register: physical address of the top-level table |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| mem_rd_en | output | 1 | Table-entry read request |
| mem_rd_addr | output | 32 | Byte address of the entry being read |
| mem_rd_valid | input | 1 | Read data valid; completes the pending read |
| mem_rd_data | input | 32 | Entry returned by memory |
| rsp_valid | output | 1 | Result valid for one cycle |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 = none, 1 = not present, 2 = protection |

## Verification
The bench builds the walker with its default split of 10/10/12 bits and four-byte entries. With these defaults, index value 1023 at both levels and frame number 0xFFFFF reach the top of the address space, so the highest entry slot and an all-ones physical address get exercised. Read latency comes from the bench's memory model and is varied from zero to three cycles, which covers both the held-request case and the back-to-back case. The same defaults let an unaligned base and a base change during a walk be compared against a walk with a clean base.

// File: rtl/page_walker.sv
module page_walker #(
  parameter int L1_W  = 10,
  parameter int L2_W  = 10,
  parameter int OFF_W = 12,
  parameter int PTE_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTE_W-1:0] root_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [PTE_W-1:0] req_vaddr,
  input  logic             req_write,
  output logic             mem_rd_en,
  output logic [PTE_W-1:0] mem_rd_addr,
  input  logic             mem_rd_valid,
  input  logic [PTE_W-1:0] mem_rd_data,
  output logic             rsp_valid,
  output logic [PTE_W-1:0] rsp_paddr,
  output logic [1:0]       rsp_fault
);
  localparam int VA_W    = L1_W + L2_W + OFF_W;
  localparam int FRAME_W = PTE_W - OFF_W;
  localparam logic [1:0] FLT_NONE   = 2'd0;
  localparam logic [1:0] FLT_ABSENT = 2'd1;
  localparam logic [1:0] FLT_PROT   = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_L1, S_L2, S_DONE} st_t;

  st_t               st;
  logic [VA_W-1:0]   va_q;
  logic              wr_q;
  logic [FRAME_W-1:0] tbl_q;
  logic [PTE_W-1:0]  paddr_q;
  logic [1:0]        fault_q;

  wire [L1_W-1:0]    idx1  = va_q[VA_W-1 -: L1_W];
  wire [L2_W-1:0]    idx2  = va_q[OFF_W +: L2_W];
  wire [FRAME_W-1:0] frame = mem_rd_data[PTE_W-1:OFF_W];
  wire [1:0]         chk   = !mem_rd_data[0] ? FLT_ABSENT :
                             (!mem_rd_data[1] || (wr_q && !mem_rd_data[2])) ? FLT_PROT :
                             FLT_NONE;

  assign req_ready   = (st == S_IDLE);
  assign mem_rd_en   = (st == S_L1) || (st == S_L2);
  assign mem_rd_addr = (st == S_L2) ? {tbl_q, OFF_W'({idx2, 2'b00})}
                                    : {tbl_q, OFF_W'({idx1, 2'b00})};
  assign rsp_valid   = (st == S_DONE);
  assign rsp_paddr   = paddr_q;
  assign rsp_fault   = fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      tbl_q   <= '0;
      paddr_q <= '0;
      fault_q <= FLT_NONE;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q  <= req_vaddr[VA_W-1:0];
          wr_q  <= req_write;
          tbl_q <= root_base[PTE_W-1:OFF_W];
          st    <= S_L1;
        end
        S_L1: if (mem_rd_valid) begin
          if (chk != FLT_NONE) begin
            fault_q <= chk;
            paddr_q <= '0;
            st      <= S_DONE;
          end else begin
            tbl_q <= frame;
            st    <= S_L2;
          end
        end
        S_L2: if (mem_rd_valid) begin
          fault_q <= chk;
          paddr_q <= (chk == FLT_NONE) ? {frame, va_q[OFF_W-1:0]} : '0;
          st      <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en && !mem_rd_valid |=> mem_rd_en && $stable(mem_rd_addr));

  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);

  // R5
  absent_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en && mem_rd_valid && !mem_rd_data[0] |=> rsp_valid && rsp_fault == FLT_ABSENT);

  // R7
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == FLT_NONE |-> rsp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]);
endmodule

// File: tb/test_page_walker.sv
`timescale 1ns/1ps
module test_page_walker;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [31:0] root_base = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic req_ready, mem_rd_en, rsp_valid;
  logic [31:0] mem_rd_addr, rsp_paddr;
  logic mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic [1:0] rsp_fault;

  page_walker i_page_walker (
    .clk(clk), .rst_n(rst_n), .root_base(root_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  int checks = 0, errors = 0, lat = 0;
  logic [31:0] mem [int unsigned];
  logic [31:0] q_pa[$];
  logic [1:0]  q_flt[$];
  string       q_tag[$];
  logic [31:0] q_rd[$];

  localparam logic [31:0] BASE = 32'h0001_0000;

  task automatic ck(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pte(input logic [19:0] f, input bit w, input bit r, input bit v);
    return {f, 9'b0, w, r, v};
  endfunction
  function automatic logic [31:0] va(input logic [9:0] i1, input logic [9:0] i2, input logic [11:0] o);
    return {i1, i2, o};
  endfunction
  function automatic logic [31:0] ent(input logic [19:0] f, input logic [9:0] i);
    return {f, i, 2'b00};
  endfunction

  // memory responder: checks each issued read against the expected address list
  int wcnt = 0;
  initial forever begin
    @(negedge clk);
    mem_rd_valid = 1'b0;
    if (rst_n && mem_rd_en) begin
      if (wcnt >= lat) begin
        wcnt = 0;
        if (q_rd.size() == 0) ck(1'b0, "R5 R8 unexpected read", mem_rd_addr, 32'h0);
        else begin
          logic [31:0] e;
          e = q_rd.pop_front();
          ck(mem_rd_addr == e, "R2 R3 R9 read address", mem_rd_addr, e);
        end
        mem_rd_data  = mem.exists(mem_rd_addr) ? mem[mem_rd_addr] : 32'h0;
        mem_rd_valid = 1'b1;
      end else wcnt++;
    end
  end

  // response monitor
  bit prev_rsp = 1'b0;
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (prev_rsp) begin
        ck(!rsp_valid, "R10 pulse", {31'b0, rsp_valid}, 32'h0);
        ck(req_ready, "R10 idle after response", {31'b0, req_ready}, 32'h1);
      end
      if (rsp_valid && !prev_rsp) begin
        if (q_pa.size() == 0) ck(1'b0, "R8 unexpected response", rsp_paddr, 32'h0);
        else begin
          logic [31:0] epa; logic [1:0] ef; string t;
          epa = q_pa.pop_front(); ef = q_flt.pop_front(); t = q_tag.pop_front();
          ck(rsp_paddr == epa, {t, " paddr"}, rsp_paddr, epa);
          ck(rsp_fault == ef, {t, " fault"}, {30'b0, rsp_fault}, {30'b0, ef});
        end
      end
      prev_rsp = rsp_valid;
    end
  end

  task automatic walk(input logic [31:0] v, input bit wr, input logic [31:0] pa, input logic [1:0] flt,
                      input string tag, input int nrd, input logic [31:0] a1, input logic [31:0] a2,
                      input bit poke);
    q_pa.push_back(pa); q_flt.push_back(flt); q_tag.push_back(tag);
    q_rd.push_back(a1);
    if (nrd == 2) q_rd.push_back(a2);
    @(negedge clk);
    ck(req_ready, "R8 ready when idle", {31'b0, req_ready}, 32'h1);
    req_valid = 1'b1; req_vaddr = v; req_write = wr;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      logic [31:0] keep;
      keep = root_base;
      ck(!req_ready, "R8 busy during walk", {31'b0, req_ready}, 32'h0);
      req_valid = 1'b1; req_vaddr = va(10'd3, 10'd0, 12'h0); root_base = 32'h0F00_0000;
      repeat (2) @(negedge clk);
      req_valid = 1'b0; root_base = keep;
    end
    while (q_pa.size() != 0) @(negedge clk);
    @(negedge clk);
    ck(q_rd.size() == 0, {tag, " read count"}, q_rd.size(), 32'h0);
    q_rd.delete();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    mem[BASE + 4]         = pte(20'h00020, 1, 1, 1);
    mem[BASE + 16]        = pte(20'h00030, 0, 1, 1);
    mem[BASE + 32'hFFC]   = pte(20'h00040, 1, 1, 1);
    mem[32'h0002_0008]    = pte(20'hABCDE, 1, 1, 1) | 32'h0000_0FF8;
    mem[32'h0002_0018]    = pte(20'h55555, 0, 1, 1);
    mem[32'h0002_001C]    = pte(20'h66666, 1, 0, 1);
    mem[32'h0003_0000]    = pte(20'h12345, 1, 1, 1);
    mem[32'h0004_0FFC]    = pte(20'hFFFFF, 1, 1, 1);
    root_base = BASE;

    repeat (3) @(negedge clk);
    ck(req_ready && !mem_rd_en && !rsp_valid, "R1 in reset",
       {29'b0, req_ready, mem_rd_en, rsp_valid}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    ck(req_ready && !mem_rd_en && !rsp_valid, "R1 after reset",
       {29'b0, req_ready, mem_rd_en, rsp_valid}, 32'h4);

    lat = 0;
    walk(va(1, 2, 12'h345), 0, 32'hABCDE345, 2'd0, "R7 R4 read ok", 2,
         ent(BASE[31:12], 1), ent(20'h00020, 2), 0);
    lat = 2;
    walk(va(1, 2, 12'h345), 1, 32'hABCDE345, 2'd0, "R7 write ok", 2,
         ent(BASE[31:12], 1), ent(20'h00020, 2), 0);
    lat = 1;
    walk(va(3, 0, 12'h010), 0, 32'h0, 2'd1, "R5 absent top", 1, ent(BASE[31:12], 3), 32'h0, 0);
    walk(va(1, 5, 12'h010), 1, 32'h0, 2'd1, "R5 absent second", 2,
         ent(BASE[31:12], 1), ent(20'h00020, 5), 0);
    lat = 0;
    walk(va(1, 6, 12'hABC), 0, 32'h55555ABC, 2'd0, "R6 read ignores write bit", 2,
         ent(BASE[31:12], 1), ent(20'h00020, 6), 0);
    walk(va(1, 6, 12'hABC), 1, 32'h0, 2'd2, "R6 write to read-only", 2,
         ent(BASE[31:12], 1), ent(20'h00020, 6), 0);
    walk(va(1, 7, 12'h001), 0, 32'h0, 2'd2, "R6 not readable", 2,
         ent(BASE[31:12], 1), ent(20'h00020, 7), 0);
    walk(va(4, 0, 12'h777), 0, 32'h12345777, 2'd0, "R6 read through read-only top", 2,
         ent(BASE[31:12], 4), ent(20'h00030, 0), 0);
    lat = 3;
    walk(va(4, 0, 12'h777), 1, 32'h0, 2'd2, "R6 write blocked at top", 1,
         ent(BASE[31:12], 4), 32'h0, 0);
    lat = 1;
    walk(32'hFFFF_FFFF, 0, 32'hFFFF_FFFF, 2'd0, "R7 R3 top slot", 2,
         ent(BASE[31:12], 10'h3FF), ent(20'h00040, 10'h3FF), 0);
    root_base = BASE | 32'h0000_0ABC;
    walk(va(1, 2, 12'h001), 0, 32'hABCDE001, 2'd0, "R2 base low bits", 2,
         ent(BASE[31:12], 1), ent(20'h00020, 2), 0);
    root_base = BASE;
    lat = 3;
    walk(va(1, 2, 12'h0F0), 1, 32'hABCDE0F0, 2'd0, "R8 R9 request during walk", 2,
         ent(BASE[31:12], 1), ent(20'h00020, 2), 1);

    repeat (4) @(negedge clk);
    ck(!rsp_valid && !mem_rd_en && req_ready, "R8 ignored request left no work",
       {29'b0, req_ready, mem_rd_en, rsp_valid}, 32'h4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule